// File: doc/BRIEF.md
# Six-Channel Tick Timer Bank

The block holds several independent 32-bit up-counters behind one register port with a single-cycle write and a combinational read. Each counter advances only on clock cycles where its chosen tick-enable input is high. That input is either a fast system tick or a slow real-time tick, and it can optionally be halved. The block is used as the timer resource of a processor subsystem. One channel typically runs free as a timestamp source, and another is armed as a one-shot or periodic event generator.

Each channel is compared against its own match value. In repeat mode, a match restarts the count. In one-shot mode, a match stops the channel. In free-run mode, the count only wraps and never matches. A match sets a sticky per-channel pending flag. Software clears pending flags by writing ones to a separate acknowledge location. A single interrupt line combines the pending flags that are enabled. Software should program a delay of at least three ticks.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every readable register returns 0 and `irq` is low.
- R2: Channel n (1 to 6) decodes at byte offsets 0x10*n (control), +0x4 (clock select), +0x8 (count) and +0xC (match). The interrupt-enable register sits at 0x00, with bit n-1 for channel n. Reads of 0x04, 0x08 and any unused location return 0. Unused bits read 0, and writes to the count register are ignored.
- R3: In the control register, bit 0 is the enable bit. Writing 1 to bit 1 zeroes the counter and restarts the halving phase. Bit 1 always reads back as 0.
- R4: With control bits 5:4 = 3 (free-run), an enabled counter adds 1 on every selected tick, wrapping after all ones. It never sets its pending flag, even when it passes the match value.
- R5: With mode 1 (repeat), a tick that finds count == match sets pending and returns the count to 0. Matches therefore recur every match+1 ticks.
- R6: With mode 0 or 2 (one-shot), a tick that finds count == match sets pending and clears the enable bit. The count holds at the match value, and the control register then reads the mode field with enable 0.
- R7: Clock-select bit 4 picks the tick source: 0 is the fast tick and 1 is the slow tick. Clock-select bit 0 set to 1 counts only every second source tick, and the first tick counted is the second one after a clear. Ticks on the unselected source have no effect.
- R8: Pending flags are sticky and are set whether or not the channel's interrupt is enabled. Writing 1 to bit n-1 at offset 0x08 clears channel n, and 0x3F clears all six. Zero bits have no effect. A match in the same cycle as its acknowledge leaves the flag set.
- R9: `irq` is the OR over channels of pending AND enable. It is high in the cycle after the match tick or after an enable write.
- R10: A disabled channel's counter does not move on ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 8 | Byte address for reads and writes |
| wdata | input | 32 | Write data |
| fast_tick | input | 1 | Fast system tick enable |
| slow_tick | input | 1 | Slow real-time tick enable |
| rdata | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
A register write takes effect at the clock edge where `wr_en` is high. Read data is combinational from `addr`, so a read issued at the next falling edge already shows the new value. A counter moves at each rising edge where its selected tick is high. A match sets pending at that same edge, and `irq` follows combinationally before the next falling edge. The bench therefore drives every strobe and tick at a falling edge. It issues reads one falling edge after the last tick or write and compares them a moment later, so each expected value counts ticks rather than wall-clock cycles.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
  localparam int unsigned TTB_DW = 32;

  typedef enum logic [1:0] {
    TTB_ONCE  = 2'd0,
    TTB_LOOP  = 2'd1,
    TTB_SPARE = 2'd2,
    TTB_FREE  = 2'd3
  } ttb_mode_e;

  typedef enum logic [1:0] {
    TTB_R_CTRL = 2'd0,
    TTB_R_CLK  = 2'd1,
    TTB_R_CNT  = 2'd2,
    TTB_R_CMP  = 2'd3
  } ttb_reg_e;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_CLR_BIT = 1;
  localparam int unsigned CTRL_MODE_LO = 4;
  localparam int unsigned CLK_DIV_BIT  = 0;
  localparam int unsigned CLK_SRC_BIT  = 4;

  function automatic logic ttb_is_once(ttb_mode_e m);
    return (m == TTB_ONCE) || (m == TTB_SPARE);
  endfunction

  function automatic logic ttb_matches(logic [TTB_DW-1:0] c, logic [TTB_DW-1:0] lim,
                                       ttb_mode_e m);
    return (m != TTB_FREE) && (c == lim);
  endfunction

  function automatic logic [TTB_DW-1:0] ttb_next(logic [TTB_DW-1:0] c,
                                                 logic [TTB_DW-1:0] lim, ttb_mode_e m);
    if (ttb_matches(c, lim, m)) begin
      return (m == TTB_LOOP) ? '0 : c;
    end
    return c + 1'b1;
  endfunction

  function automatic logic [TTB_DW-1:0] ttb_ctrl_view(ttb_mode_e m, logic en);
    logic [TTB_DW-1:0] v;
    v = '0;
    v[CTRL_MODE_LO +: 2] = m;
    v[CTRL_EN_BIT]       = en;
    return v;
  endfunction

  function automatic logic [TTB_DW-1:0] ttb_clk_view(logic slow, logic halve);
    logic [TTB_DW-1:0] v;
    v = '0;
    v[CLK_SRC_BIT] = slow;
    v[CLK_DIV_BIT] = halve;
    return v;
  endfunction
endpackage

// File: rtl/ttb_tick_sel.sv
module ttb_tick_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_tick,
  input  logic slow_tick,
  input  logic use_slow,
  input  logic halve,
  input  logic restart,
  output logic tick_o
);
  logic src;
  logic phase_q;

  assign src = use_slow ? slow_tick : fast_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else if (restart) begin
      phase_q <= 1'b0;
    end else if (src && halve) begin
      phase_q <= ~phase_q;
    end
  end

  // halved: pass only the source ticks that find the phase set
  assign tick_o = src && (!halve || phase_q);
endmodule

// File: rtl/ttb_channel.sv
module ttb_channel
  import ttb_pkg::*;
#(
  parameter int unsigned DW = TTB_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic          clk_we,
  input  logic          cmp_we,
  input  logic [DW-1:0] wdata,
  input  logic          ack,
  input  logic          fast_tick,
  input  logic          slow_tick,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] cmp_o,
  output logic [DW-1:0] ctrl_rd_o,
  output logic [DW-1:0] clk_rd_o,
  output logic          en_o,
  output ttb_mode_e     mode_o,
  output logic          hit_o,
  output logic          pend_o
);
  logic          en_q;
  ttb_mode_e     mode_q;
  logic          slow_q;
  logic          halve_q;
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] cmp_q;
  logic          pend_q;
  logic          clr_now;
  logic          tick;
  logic          run_tick;
  logic          hit;

  assign clr_now = ctrl_we && wdata[CTRL_CLR_BIT];

  ttb_tick_sel u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .fast_tick (fast_tick),
    .slow_tick (slow_tick),
    .use_slow  (slow_q),
    .halve     (halve_q),
    .restart   (clr_now),
    .tick_o    (tick)
  );

  assign run_tick = en_q && tick;
  assign hit      = run_tick && !clr_now && ttb_matches(cnt_q, cmp_q, mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= TTB_ONCE;
    end else if (ctrl_we) begin
      en_q   <= wdata[CTRL_EN_BIT];
      mode_q <= ttb_mode_e'(wdata[CTRL_MODE_LO +: 2]);
    end else if (hit && ttb_is_once(mode_q)) begin
      en_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q  <= 1'b0;
      halve_q <= 1'b0;
    end else if (clk_we) begin
      slow_q  <= wdata[CLK_SRC_BIT];
      halve_q <= wdata[CLK_DIV_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (cmp_we) begin
      cmp_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_now) begin
      cnt_q <= '0;
    end else if (run_tick) begin
      cnt_q <= ttb_next(cnt_q, cmp_q, mode_q);
    end
  end

  // a new match outranks an acknowledge in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (hit) begin
      pend_q <= 1'b1;
    end else if (ack) begin
      pend_q <= 1'b0;
    end
  end

  assign cnt_o     = cnt_q;
  assign cmp_o     = cmp_q;
  assign ctrl_rd_o = ttb_ctrl_view(mode_q, en_q);
  assign clk_rd_o  = ttb_clk_view(slow_q, halve_q);
  assign en_o      = en_q;
  assign mode_o    = mode_q;
  assign hit_o     = hit;
  assign pend_o    = pend_q;
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import ttb_pkg::*;
#(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TTB_DW-1:0] wdata,
  input  logic              fast_tick,
  input  logic              slow_tick,
  output logic [TTB_DW-1:0] rdata,
  output logic              irq
);
  localparam int unsigned DW    = TTB_DW;
  localparam int unsigned IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0] idx;
  ttb_reg_e         sel;
  logic             aligned;
  logic             ien_we;
  logic             ack_we;
  logic [NUM_CH-1:0] ien_q;
  logic [NUM_CH-1:0] ack_mask;

  logic [NUM_CH-1:0] hit_vec;
  logic [NUM_CH-1:0] pend_vec;
  logic [NUM_CH-1:0] en_vec;
  logic [NUM_CH-1:0] once_vec;
  logic [NUM_CH-1:0] free_vec;
  logic [NUM_CH-1:0] ctrl_we_vec;
  logic [NUM_CH-1:0] clk_we_vec;
  logic [NUM_CH-1:0] cmp_we_vec;

  logic [DW-1:0] cnt_arr  [NUM_CH];
  logic [DW-1:0] cmp_arr  [NUM_CH];
  logic [DW-1:0] ctrl_arr [NUM_CH];
  logic [DW-1:0] clk_arr  [NUM_CH];

  assign idx     = addr[ADDR_W-1:4];
  assign sel     = ttb_reg_e'(addr[3:2]);
  assign aligned = (addr[1:0] == 2'b00);

  // shared slots live in the block of index 0
  assign ien_we   = wr_en && aligned && (idx == '0) && (sel == TTB_R_CTRL);
  assign ack_we   = wr_en && aligned && (idx == '0) && (sel == TTB_R_CNT);
  assign ack_mask = ack_we ? wdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
    end else if (ien_we) begin
      ien_q <= wdata[NUM_CH-1:0];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ttb_mode_e mode_w;
    logic      slot;

    assign slot           = wr_en && aligned && (idx == IDX_W'(g + 1));
    assign ctrl_we_vec[g] = slot && (sel == TTB_R_CTRL);
    assign clk_we_vec[g]  = slot && (sel == TTB_R_CLK);
    assign cmp_we_vec[g]  = slot && (sel == TTB_R_CMP);

    ttb_channel #(.DW(DW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_we   (ctrl_we_vec[g]),
      .clk_we    (clk_we_vec[g]),
      .cmp_we    (cmp_we_vec[g]),
      .wdata     (wdata),
      .ack       (ack_mask[g]),
      .fast_tick (fast_tick),
      .slow_tick (slow_tick),
      .cnt_o     (cnt_arr[g]),
      .cmp_o     (cmp_arr[g]),
      .ctrl_rd_o (ctrl_arr[g]),
      .clk_rd_o  (clk_arr[g]),
      .en_o      (en_vec[g]),
      .mode_o    (mode_w),
      .hit_o     (hit_vec[g]),
      .pend_o    (pend_vec[g])
    );

    assign once_vec[g] = ttb_is_once(mode_w);
    assign free_vec[g] = (mode_w == TTB_FREE);
  end

  always_comb begin
    rdata = '0;
    if (aligned) begin
      if ((idx == '0) && (sel == TTB_R_CTRL)) begin
        rdata = DW'(ien_q);
      end
      for (int i = 0; i < NUM_CH; i++) begin
        if (idx == IDX_W'(i + 1)) begin
          case (sel)
            TTB_R_CTRL: rdata = ctrl_arr[i];
            TTB_R_CLK:  rdata = clk_arr[i];
            TTB_R_CNT:  rdata = cnt_arr[i];
            default:    rdata = cmp_arr[i];
          endcase
        end
      end
    end
  end

  assign irq = |(pend_vec & ien_q);
endmodule

// File: rtl/ttb_checker.sv
module ttb_checker #(
  parameter int unsigned NUM_CH = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] hit_vec,
  input logic [NUM_CH-1:0] pend_vec,
  input logic [NUM_CH-1:0] en_vec,
  input logic [NUM_CH-1:0] once_vec,
  input logic [NUM_CH-1:0] free_vec,
  input logic [NUM_CH-1:0] ctrl_we_vec,
  input logic [NUM_CH-1:0] ack_mask,
  input logic              ien_we,
  input logic              irq
);
  assert_free_never_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & free_vec) == '0);

  assert_hit_sets_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |=> ((pend_vec & $past(hit_vec)) == $past(hit_vec)));

  assert_pending_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_vec) & ~pend_vec & ~$past(ack_mask)) == '0));

  assert_once_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit_vec & once_vec & ~ctrl_we_vec))
      |=> ((en_vec & $past(hit_vec & once_vec & ~ctrl_we_vec)) == '0));

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|hit_vec) || $past(ien_we)));
endmodule

bind tick_timer_bank ttb_checker #(.NUM_CH(NUM_CH)) u_ttb_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hit_vec     (hit_vec),
  .pend_vec    (pend_vec),
  .en_vec      (en_vec),
  .once_vec    (once_vec),
  .free_vec    (free_vec),
  .ctrl_we_vec (ctrl_we_vec),
  .ack_mask    (ack_mask),
  .ien_we      (ien_we),
  .irq         (irq)
);

// File: tb/test_tick_timer_bank.sv
module test_tick_timer_bank;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        fast_tick = 1'b0;
  logic        slow_tick = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       req;
    string       what;
  } item_t;

  item_t sb_q[$];
  event  mon_ev;

  tick_timer_bank i_tick_timer_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .fast_tick (fast_tick),
    .slow_tick (slow_tick),
    .rdata     (rdata),
    .irq       (irq)
  );

  always #(CLK_PER / 2) clk = ~clk;

  function automatic logic [7:0] ch_addr(int n, int reg_no);
    return 8'(16 * n + 4 * reg_no);
  endfunction

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(mon_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = it.is_irq ? {31'd0, irq} : rdata;
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s %s: actual=%h expected=%h", it.req, it.what, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string req,
                        input string what);
    item_t it;
    @(negedge clk);
    addr = a;
    #1;
    it.is_irq = 1'b0; it.exp = e; it.req = req; it.what = what;
    sb_q.push_back(it);
    -> mon_ev;
  endtask

  task automatic irq_chk(input logic e, input string req, input string what);
    item_t it;
    @(negedge clk);
    #1;
    it.is_irq = 1'b1; it.exp = {31'd0, e}; it.req = req; it.what = what;
    sb_q.push_back(it);
    -> mon_ev;
  endtask

  task automatic pulse(input bit slow, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (slow) slow_tick = 1'b1; else fast_tick = 1'b1;
    end
    @(negedge clk);
    fast_tick = 1'b0; slow_tick = 1'b0;
  endtask

  task automatic ack_with_tick(input logic [31:0] m);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h08; wdata = m; fast_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; fast_tick = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PER * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk(8'h00, 32'h0, "R1", "ien after reset");
    rd_chk(ch_addr(1, 0), 32'h0, "R1", "ch1 ctrl after reset");
    rd_chk(ch_addr(3, 2), 32'h0, "R1", "ch3 count after reset");
    rd_chk(ch_addr(6, 3), 32'h0, "R1", "ch6 match after reset");
    irq_chk(1'b0, "R1", "irq after reset");

    // R2 / R3 map, reserved bits, count write ignored
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk(8'h00, 32'h0000_003F, "R2", "ien masks unused bits");
    wr(8'h00, 32'h0);
    wr(ch_addr(2, 1), 32'hFFFF_FFFF);
    rd_chk(ch_addr(2, 1), 32'h0000_0011, "R2", "ch2 clock unused bits");
    wr(ch_addr(2, 0), 32'hFFFF_FFFF);
    rd_chk(ch_addr(2, 0), 32'h0000_0031, "R3", "ch2 ctrl clear bit reads 0");
    wr(ch_addr(2, 0), 32'h0);
    wr(ch_addr(2, 2), 32'h0000_1234);
    rd_chk(ch_addr(2, 2), 32'h0, "R2", "ch2 count ignores writes");
    wr(ch_addr(2, 3), 32'hA5A5_0001);
    rd_chk(ch_addr(2, 3), 32'hA5A5_0001, "R2", "ch2 match readback");
    rd_chk(8'h04, 32'h0, "R2", "offset 0x04 reads 0");
    rd_chk(8'h08, 32'h0, "R2", "ack slot reads 0");

    // R4 free-run passes the match value without pending
    wr(ch_addr(1, 3), 32'd5);
    wr(8'h00, 32'h01);
    wr(ch_addr(1, 0), 32'h33);
    pulse(1'b0, 10);
    rd_chk(ch_addr(1, 2), 32'd10, "R4", "ch1 free-run count");
    irq_chk(1'b0, "R4", "free-run raises no pending");
    wr(ch_addr(1, 0), 32'h02);
    rd_chk(ch_addr(1, 2), 32'd0, "R3", "clear zeroes count");
    pulse(1'b0, 4);
    rd_chk(ch_addr(1, 2), 32'd0, "R10", "disabled count holds");
    wr(8'h00, 32'h0);

    // R5 repeat, period match+1
    wr(ch_addr(3, 3), 32'd3);
    wr(8'h00, 32'h04);
    wr(ch_addr(3, 0), 32'h13);
    pulse(1'b0, 3);
    rd_chk(ch_addr(3, 2), 32'd3, "R5", "ch3 at match value");
    irq_chk(1'b0, "R5", "no pending before match tick");
    pulse(1'b0, 1);
    rd_chk(ch_addr(3, 2), 32'd0, "R5", "ch3 restarts after match");
    irq_chk(1'b1, "R9", "irq after repeat match");
    wr(8'h08, 32'h04);
    irq_chk(1'b0, "R8", "ack clears ch3");
    pulse(1'b0, 4);
    rd_chk(ch_addr(3, 2), 32'd0, "R5", "ch3 second period");
    irq_chk(1'b1, "R5", "second match after match+1 ticks");
    wr(8'h08, 32'h04);
    wr(ch_addr(3, 0), 32'h0);
    wr(8'h00, 32'h0);

    // R6 one-shot (mode 0 and mode 2), pending while interrupt disabled
    wr(ch_addr(4, 3), 32'd4);
    wr(ch_addr(4, 0), 32'h03);
    pulse(1'b0, 6);
    rd_chk(ch_addr(4, 2), 32'd4, "R6", "ch4 holds at match");
    rd_chk(ch_addr(4, 0), 32'h0, "R6", "ch4 enable cleared");
    wr(ch_addr(5, 3), 32'd2);
    wr(ch_addr(5, 0), 32'h23);
    pulse(1'b0, 5);
    rd_chk(ch_addr(5, 2), 32'd2, "R6", "mode 2 holds at match");
    rd_chk(ch_addr(5, 0), 32'h20, "R6", "mode 2 enable cleared");
    irq_chk(1'b0, "R9", "irq masked while ien 0");
    wr(8'h00, 32'h08);
    irq_chk(1'b1, "R8", "pending kept while disabled");
    wr(8'h08, 32'h37);
    irq_chk(1'b1, "R8", "zero ack bit leaves ch4");
    wr(8'h00, 32'h10);
    irq_chk(1'b0, "R8", "ch5 cleared by its ack bit");
    wr(8'h08, 32'h3F);
    wr(8'h00, 32'h08);
    irq_chk(1'b0, "R8", "0x3F clears all");
    wr(8'h00, 32'h0);

    // R7 source select and halving
    wr(ch_addr(6, 3), 32'd100);
    wr(ch_addr(6, 1), 32'h10);
    wr(ch_addr(6, 0), 32'h33);
    pulse(1'b0, 5);
    rd_chk(ch_addr(6, 2), 32'd0, "R7", "fast ticks ignored on slow source");
    pulse(1'b1, 3);
    rd_chk(ch_addr(6, 2), 32'd3, "R7", "slow ticks counted");
    wr(ch_addr(6, 1), 32'h11);
    wr(ch_addr(6, 0), 32'h33);
    pulse(1'b1, 5);
    rd_chk(ch_addr(6, 2), 32'd2, "R7", "halved slow source");
    wr(ch_addr(6, 0), 32'h0);

    // R8 match wins over simultaneous ack
    wr(ch_addr(1, 3), 32'd0);
    wr(8'h00, 32'h01);
    wr(ch_addr(1, 0), 32'h13);
    ack_with_tick(32'h01);
    irq_chk(1'b1, "R8", "match beats same-cycle ack");
    wr(ch_addr(1, 0), 32'h02);
    wr(8'h08, 32'h01);
    irq_chk(1'b0, "R9", "irq drops after ack");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule